// File: doc/BRIEF.md
# Gated Prescaled Down-Counter Timer

This block is an 8-bit down-counter driven through a 7-bit power-of-two prescaler. A two-bit mode field selects where the prescaler's count ticks come from, and whether the timer pin is an input or an output. In event mode, every rising edge of the synchronised pin is one tick. In gated mode, ticks from an internal divide-by-12 reference pass only while the pin is high, so the amount counted measures the length of a high pulse. In the two drive modes the pin becomes an output, counting runs from the divide-by-12 reference, and each underflow places the level given by the low mode bit on the pin.

Software writes a load value. The write sets the live count and the reload register, and restarts the prescaler. When the count is at zero and one more decrement falls due, the counter reloads and sets a sticky underflow flag. A write-one strobe clears that flag.

Two small state machines carry the control. The mode decoder is a combinational state taken from the mode bits, with the states SRC_EVENT, SRC_GATED, SRC_DRIVE0 and SRC_DRIVE1; it changes whenever the mode bits change. The pin-level machine has the states LVL_LOW and LVL_HIGH. It moves LVL_LOW→LVL_HIGH on an underflow in SRC_DRIVE1, and LVL_HIGH→LVL_LOW on an underflow in SRC_DRIVE0. In every other case it stays where it is.

Top module: `gated_down_timer`

## Requirements
- R1: While reset is asserted and on release, the count, the reload value, the underflow flag and the pin level are all 0, and the reference divider restarts its 12-cycle period.
- R2: With mode 00 (event), each rising edge of the pin, after a two-flop synchroniser, is one prescaler tick. The count changes on the third rising clock edge after the pin is first sampled high.
- R3: With mode 01 (gated), a reference tick reaches the prescaler only while the synchronised pin is 1. While the pin is 0 the count does not move.
- R4: With modes 10 and 11 (drive), the prescaler takes every reference tick. The output enable equals the high mode bit, so it is 1 in drive modes and 0 in input modes.
- R5: The reference tick repeats once every 12 clock cycles and never stops, so any 120 consecutive cycles in drive mode with ratio 1 give exactly 10 decrements.
- R6: A 3-bit tap n sets a prescale ratio of 2^n. Exactly one count decrement happens per 2^n ticks after a load.
- R7: When a decrement falls due while the count is 0, the count takes the reload value and the underflow flag becomes 1 on that same edge.
- R8: A clear strobe drops the underflow flag on the next edge, unless an underflow happens on that same edge, in which case the flag stays 1.
- R9: In drive modes, the pin level becomes the low mode bit on each underflow and holds its value at all other times, including across mode changes.
- R10: A load strobe writes the count and the reload register on the next edge and restarts the prescaler at its full period. A load wins over a decrement due on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 event, 01 gated, 10 drive low, 11 drive high |
| tap_i | input | 3 | Prescale exponent n, ratio 2^n |
| load_we_i | input | 1 | Load strobe for count and reload value |
| load_val_i | input | 8 | Value written by the load strobe |
| uf_clr_i | input | 1 | Write-one strobe that clears the underflow flag |
| pin_i | input | 1 | Timer pin input level |
| cnt_o | output | 8 | Current count |
| uf_o | output | 1 | Sticky underflow flag |
| pin_o | output | 1 | Level driven on the pin in drive modes |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
A load shows on the count one edge after its strobe. A pin rise shows on the count on the third edge after it is first sampled. An underflow moves the count, the flag and the pin level on the same edge, and the output enable follows the mode bits with no register. The bench keeps a behavioural model that steps on the same edge as the design and compares all four outputs 1 ns after every rising edge, so each result is checked in the cycle it is due. Directed checks then read settled values at falling edges after a counted number of cycles, with each count worked out from the latencies above.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        SRC_EVENT  = 2'b00,
        SRC_GATED  = 2'b01,
        SRC_DRIVE0 = 2'b10,
        SRC_DRIVE1 = 2'b11
    } src_state_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
    end

    assign tick_o = (phase_q == LAST);

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

    // R2
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pow2_prescaler.sv
module pow2_prescaler #(
    parameter int W    = 7,
    parameter int TAPW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            restart_i,
    input  logic [TAPW-1:0] tap_i,
    output logic            term_o
);
    logic [W-1:0] left_q;
    logic [W-1:0] mask;
    logic [W:0]   span;
    int           eff;

    always_comb begin
        eff  = (int'(tap_i) > W) ? W : int'(tap_i);
        span = ((W+1)'(1) << eff) - (W+1)'(1);
        mask = span[W-1:0];
    end

    assign term_o = tick_i && (left_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         left_q <= '0;
        else if (restart_i) left_q <= mask;
        else if (term_o)    left_q <= mask;
        else if (tick_i)    left_q <= left_q - 1'b1;
    end

    // R10
    restart_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (left_q == $past(mask)));
endmodule

// File: rtl/gated_down_timer.sv
module gated_down_timer #(
    parameter int CNT_W    = 8,
    parameter int PSC_W    = 7,
    parameter int TAP_W    = 3,
    parameter int REF_DIV  = 12,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [TAP_W-1:0] tap_i,
    input  logic             load_we_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             uf_clr_i,
    input  logic             pin_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             uf_o,
    output logic             pin_o,
    output logic             pin_oe_o
);
    import tmr_pkg::*;

    logic             ref_tick, pin_lvl, pin_rise, src_tick, term;
    logic             uf_event;
    logic [CNT_W-1:0] cnt_q, reload_q;
    logic             uf_q;
    src_state_e       src_st;
    lvl_state_e       lvl_q, lvl_d;

    ref_divider #(.DIV(REF_DIV)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick_o(ref_tick));

    pin_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .level_o(pin_lvl), .rise_o(pin_rise));

    assign src_st = src_state_e'(mode_i);

    always_comb begin
        unique case (src_st)
            SRC_EVENT:  src_tick = pin_rise;
            SRC_GATED:  src_tick = ref_tick & pin_lvl;
            SRC_DRIVE0: src_tick = ref_tick;
            SRC_DRIVE1: src_tick = ref_tick;
            default:    src_tick = 1'b0;
        endcase
    end

    pow2_prescaler #(.W(PSC_W), .TAPW(TAP_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .tick_i(src_tick),
        .restart_i(load_we_i), .tap_i(tap_i), .term_o(term));

    assign uf_event = term && !load_we_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (load_we_i) begin
            cnt_q    <= load_val_i;
            reload_q <= load_val_i;
        end else if (uf_event) begin
            cnt_q    <= reload_q;
        end else if (term) begin
            cnt_q    <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        uf_q <= 1'b0;
        else if (uf_event) uf_q <= 1'b1;
        else if (uf_clr_i) uf_q <= 1'b0;
    end

    // pin-level state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_LOW;
        else        lvl_q <= lvl_d;
    end

    // pin-level transitions
    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_LOW:  if (uf_event && src_st == SRC_DRIVE1) lvl_d = LVL_HIGH;
            LVL_HIGH: if (uf_event && src_st == SRC_DRIVE0) lvl_d = LVL_LOW;
            default:  lvl_d = LVL_LOW;
        endcase
    end

    // outputs
    always_comb begin
        cnt_o    = cnt_q;
        uf_o     = uf_q;
        pin_o    = (lvl_q == LVL_HIGH);
        pin_oe_o = (src_st == SRC_DRIVE0) || (src_st == SRC_DRIVE1);
    end

    // R7
    uf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !load_we_i && cnt_q == '0) |=> (cnt_q == $past(reload_q)) && uf_q);
    // R8
    uf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_clr_i && !uf_event) |=> !uf_q);
    // R10
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_we_i |=> (cnt_q == $past(load_val_i)) && (reload_q == $past(load_val_i)));
    // R9
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_event |=> $stable(lvl_q));
    // R3
    gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_st == SRC_GATED && !pin_lvl && !load_we_i) |=> $stable(cnt_q));
endmodule

// File: tb/test_gated_down_timer.sv
module test_gated_down_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [2:0] tap_i = 3'd0;
    logic       load_we_i = 1'b0;
    logic [7:0] load_val_i = 8'd0;
    logic       uf_clr_i = 1'b0;
    logic       pin_i = 1'b0;
    logic [7:0] cnt_o;
    logic       uf_o, pin_o, pin_oe_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_div, m_s1, m_s2, m_s3, m_psc, m_cnt, m_rel, m_uf, m_lvl;

    always #2.5 clk = ~clk;

    gated_down_timer i_gated_down_timer (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tap_i(tap_i),
        .load_we_i(load_we_i), .load_val_i(load_val_i), .uf_clr_i(uf_clr_i),
        .pin_i(pin_i), .cnt_o(cnt_o), .uf_o(uf_o), .pin_o(pin_o),
        .pin_oe_o(pin_oe_o));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        int ref_t, rise, src, mask, term, ufset;
        cyc++;
        if (!rst_n) begin
            m_div = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_psc = 0;
            m_cnt = 0; m_rel = 0; m_uf = 0; m_lvl = 0;
        end else begin
            ref_t = (m_div == 11);
            rise  = (m_s2 == 1 && m_s3 == 0);
            case (mode_i)
                2'b00:   src = rise;
                2'b01:   src = ref_t && m_s2 == 1;
                default: src = ref_t;
            endcase
            mask  = (1 << tap_i) - 1;
            term  = 0;
            ufset = 0;
            if (load_we_i) m_psc = mask;
            else if (src) begin
                if (m_psc == 0) begin term = 1; m_psc = mask; end
                else m_psc = m_psc - 1;
            end
            if (load_we_i) begin
                m_cnt = load_val_i; m_rel = load_val_i;
            end else if (term) begin
                if (m_cnt == 0) begin m_cnt = m_rel; ufset = 1; end
                else m_cnt = m_cnt - 1;
            end
            if (ufset) m_uf = 1;
            else if (uf_clr_i) m_uf = 0;
            if (ufset && mode_i[1]) m_lvl = mode_i[0];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_i;
            m_div = (m_div + 1) % 12;
        end
        #1;
        if (!done) begin
            check(cur_req, cnt_o, m_cnt);
            check("R7", uf_o, m_uf);
            check("R9", pin_o, m_lvl);
            check("R4", pin_oe_o, mode_i[1]);
        end
        if (cyc > 200000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 200000);
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input int v);
        load_we_i = 1'b1; load_val_i = 8'(v);
        step(1);
        load_we_i = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin_i = 1'b1; step(3);
            pin_i = 1'b0; step(3);
        end
    endtask

    initial begin
        int held;
        step(4);
        // R1 reset state
        check("R1", cnt_o, 0);
        check("R1", uf_o, 0);
        check("R1", pin_o, 0);
        rst_n = 1'b1;
        step(1);

        // R10 load, drive-low mode
        cur_req = "R10";
        mode_i = 2'b10; tap_i = 3'd0;
        do_load(5);
        check("R10", cnt_o, 5);
        cur_req = "R7";
        step(100);
        check("R9", pin_o, 0);
        mode_i = 2'b11;
        step(80);
        check("R9", pin_o, 1);
        check("R7", uf_o, 1);

        // R8 clear
        cur_req = "R8";
        mode_i = 2'b01; pin_i = 1'b0;
        step(4);
        uf_clr_i = 1'b1; step(1); uf_clr_i = 1'b0;
        check("R8", uf_o, 0);
        check("R9", pin_o, 1);

        // R2 event counting
        cur_req = "R2";
        mode_i = 2'b00; tap_i = 3'd0;
        do_load(20);
        pulses(8);
        step(5);
        check("R2", cnt_o, 12);

        // R6 prescale ratio
        cur_req = "R6";
        tap_i = 3'd2;
        do_load(50);
        pulses(16);
        step(5);
        check("R6", cnt_o, 46);

        // R3 gated measurement
        cur_req = "R3";
        mode_i = 2'b01; tap_i = 3'd0;
        do_load(200);
        pin_i = 1'b1; step(60);
        pin_i = 1'b0; step(4);
        held = cnt_o;
        step(100);
        check("R3", cnt_o, held);

        // R5 reference period
        cur_req = "R5";
        mode_i = 2'b10; tap_i = 3'd0;
        do_load(100);
        step(119);
        check("R5", cnt_o, 90);

        // R7 reload from small value, drive-low
        cur_req = "R7";
        do_load(2);
        step(60);
        check("R9", pin_o, 0);
        check("R4", pin_oe_o, 1);

        step(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule